// File: doc/BRIEF.md
# Shared-Decoder Multi-String Byte Scanner

This block watches the payload bytes of a network frame, one byte per clock, and reports which of a fixed set of byte strings appear anywhere in the frame. The strings are chosen when the design is elaborated. Each accepted byte is decoded once into 256 character-select lines. Every string is a chain of single-bit stages that reads only the select lines of its own characters. A stage records that the string's prefix, up to and including that stage's character, ends at the most recent byte. Because every stage of every chain updates in parallel, any number of overlapping partial matches can be tracked at the same time.

Framing comes from a start-of-frame mark and an end-of-frame mark, both carried with the payload bytes. The result is a sticky match vector with one bit per string, which later decision logic combines with header results. A one-cycle hit pulse after the last byte says whether the frame matched any string at all.

Top module: `nfa_string_scanner`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `match_o` is all zeros and `hit_o` is 0.
- R2: String i (characters in `PAT_STR` byte slot i*MAX_LEN+k, length in `PAT_LEN` byte i) is detected at any payload offset, including offset 0 and ending on the final byte. `match_o[i]` becomes 1 in the cycle after the byte that completes it. With the default parameters, bit 0 is "abb", bit 1 is "dcb" and bit 2 is "abab".
- R3: Overlapping occurrences and repeated prefixes are detected, e.g. "aabb" sets the "abb" bit and "ababab" sets the "abab" bit.
- R4: A set `match_o` bit stays set, through later bytes and idle cycles, until the next start-of-frame.
- R5: `sof_i` clears every partial match and the match vector. A string split across two frames is not detected. The byte that carries `sof_i` may itself begin a match.
- R6: A cycle with `valid_i` low leaves all stage state unchanged, and its `data_i` value is ignored. Gaps between bytes therefore neither break nor create a match.
- R7: `hit_o` is 1 for exactly the cycle after a valid byte carrying `eof_i`, and only if at least one string occurs in that frame. In every other cycle it is 0.
- R8: For any payload, the match vector at end of frame equals a plain substring search of the frame for each string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Payload byte present on `data_i` this cycle |
| data_i | input | 8 | Payload byte |
| sof_i | input | 1 | First byte of a frame (clears state, alone or with a byte) |
| eof_i | input | 1 | Last byte of a frame, qualified by `valid_i` |
| match_o | output | NUM_PAT | Sticky per-string match vector |
| hit_o | output | 1 | One-cycle pulse after end of frame: any string found |

## Verification
The bound checker watches, on every cycle, that match bits only grow between start-of-frame marks, that idle cycles leave the vector frozen and the pulse low, that a start mark without a byte empties the vector, and that the hit pulse only follows an end-of-frame byte and agrees with the vector. Whether a given string really matches a given payload needs the bench's reference search. This covers detection at offset 0 and at the final byte, overlapping repeats, strings split across frames, and gap bytes whose values must be ignored. These can only be shown by the directed and random frames.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef logic [7:0] sym_t;

  localparam int unsigned ALPHABET = 256;
  localparam int unsigned LEN_FIELD_W = 8;

  // Default string set: slot k of string i sits in byte i*MAX_LEN+k.
  localparam int unsigned DEF_NUM_PAT = 3;
  localparam int unsigned DEF_MAX_LEN = 4;
  // string 2 "abab", string 1 "dcb", string 0 "abb" (first char lowest)
  localparam logic [DEF_NUM_PAT*DEF_MAX_LEN*8-1:0] DEF_PAT_STR =
    96'h62616261_00626364_00626261;
  localparam logic [DEF_NUM_PAT*LEN_FIELD_W-1:0] DEF_PAT_LEN = 24'h04_03_03;
endpackage

// File: rtl/char_decoder.sv
module char_decoder
  import scan_pkg::*;
(
  input  logic                valid_i,
  input  sym_t                sym_i,
  output logic [ALPHABET-1:0] sel_o
);
  for (genvar c = 0; c < ALPHABET; c++) begin : g_line
    assign sel_o[c] = valid_i & (sym_i == 8'(c));
  end
endmodule

// File: rtl/pattern_chain.sv
module pattern_chain #(
  parameter int unsigned LEN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           sof_i,
  input  logic [LEN-1:0] ch_i,    // decoded select line per string position
  output logic           done_o   // this byte completes the string
);
  if (LEN == 1) begin : g_single
    assign done_o = adv_i & ch_i[0];
  end else begin : g_chain
    localparam int unsigned NST = LEN - 1;
    logic [NST-1:0] st_q, st_d, st_prev;
    logic           st_en;

    // a start mark drops any prefix seen in the previous frame
    assign st_prev = sof_i ? '0 : st_q;
    assign st_en   = adv_i | sof_i;

    assign st_d[0] = adv_i & ch_i[0];
    for (genvar k = 1; k < NST; k++) begin : g_stage
      assign st_d[k] = adv_i & ch_i[k] & st_prev[k-1];
    end

    assign done_o = adv_i & ch_i[LEN-1] & st_prev[NST-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= '0;
      else if (st_en) st_q <= st_d;
    end
  end
endmodule

// File: rtl/match_collector.sv
module match_collector #(
  parameter int unsigned NP = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          eof_i,
  input  logic [NP-1:0] done_i,
  output logic [NP-1:0] match_o,
  output logic          hit_o
);
  logic [NP-1:0] match_q, match_d;
  logic          hit_q, hit_d;

  always_comb begin
    match_d = (sof_i ? '0 : match_q) | done_i;
    hit_d   = valid_i & eof_i & (|match_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      match_q <= match_d;
      hit_q   <= hit_d;
    end
  end

  assign match_o = match_q;
  assign hit_o   = hit_q;
endmodule

// File: rtl/nfa_string_scanner.sv
module nfa_string_scanner
  import scan_pkg::*;
#(
  parameter int unsigned NUM_PAT = DEF_NUM_PAT,
  parameter int unsigned MAX_LEN = DEF_MAX_LEN,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0]     PAT_STR = DEF_PAT_STR,
  parameter logic [NUM_PAT*LEN_FIELD_W-1:0]   PAT_LEN = DEF_PAT_LEN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [7:0]         data_i,
  input  logic               sof_i,
  input  logic               eof_i,
  output logic [NUM_PAT-1:0] match_o,
  output logic               hit_o
);
  localparam int unsigned SLOT_W = MAX_LEN * 8;

  logic [ALPHABET-1:0] sel;
  logic [NUM_PAT-1:0]  done;

  char_decoder u_dec (
    .valid_i (valid_i),
    .sym_i   (data_i),
    .sel_o   (sel)
  );

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
    localparam int unsigned LEN = int'(PAT_LEN[i*LEN_FIELD_W +: LEN_FIELD_W]);
    localparam logic [SLOT_W-1:0] STR = PAT_STR[i*SLOT_W +: SLOT_W];
    logic [LEN-1:0] lines;

    for (genvar k = 0; k < LEN; k++) begin : g_line
      assign lines[k] = sel[STR[k*8 +: 8]];
    end

    pattern_chain #(.LEN(LEN)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (valid_i),
      .sof_i  (sof_i),
      .ch_i   (lines),
      .done_o (done[i])
    );
  end

  match_collector #(.NP(NUM_PAT)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sof_i   (sof_i),
    .eof_i   (eof_i),
    .done_i  (done),
    .match_o (match_o),
    .hit_o   (hit_o)
  );
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int unsigned NP = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          sof_i,
  input logic          eof_i,
  input logic [NP-1:0] match_o,
  input logic          hit_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (match_o == '0) && !hit_o);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> ((match_o & $past(match_o)) == $past(match_o)));

  p_sof_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !valid_i) |=> (match_o == '0));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !sof_i) |=> $stable(match_o) && !hit_o);

  p_hit_after_eof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(valid_i && eof_i));

  p_hit_agrees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_o != '0));
endmodule

bind nfa_string_scanner scan_checker #(.NP(NUM_PAT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sof_i   (sof_i),
  .eof_i   (eof_i),
  .match_o (match_o),
  .hit_o   (hit_o)
);

// File: tb/tb_nfa_string_scanner.sv
module tb_nfa_string_scanner;
  import scan_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = DEF_NUM_PAT;
  localparam int ML = DEF_MAX_LEN;
  localparam int MAXF = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid, sof, eof;
  logic [7:0]    data;
  logic [NP-1:0] match;
  logic          hit;

  int nvec = 0;
  int nerr = 0;

  logic [7:0] frm [MAXF];
  int         flen;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfa_string_scanner dut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .data_i (data),
    .sof_i (sof), .eof_i (eof), .match_o (match), .hit_o (hit)
  );

  function automatic logic [NP-1:0] ref_scan();
    logic [NP-1:0] r = '0;
    for (int i = 0; i < NP; i++) begin
      int len = int'(DEF_PAT_LEN[i*LEN_FIELD_W +: LEN_FIELD_W]);
      for (int s = 0; s + len <= flen; s++) begin
        bit ok = 1'b1;
        for (int k = 0; k < len; k++)
          if (frm[s+k] != DEF_PAT_STR[(i*ML+k)*8 +: 8]) ok = 1'b0;
        if (ok) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [NP:0] act, logic [NP:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive on the falling edge; results are visible at the next falling edge
  task automatic drive(logic v, logic [7:0] d, logic s, logic e);
    valid = v; data = d; sof = s; eof = e;
    @(negedge clk);
  endtask

  task automatic load(string s);
    flen = s.len();
    for (int j = 0; j < flen; j++) frm[j] = s[j];
  endtask

  task automatic send_frame(int gap_pct);
    for (int j = 0; j < flen; j++) begin
      if ($urandom_range(99) < gap_pct)
        drive(1'b0, 8'($urandom), 1'b0, 1'b0);
      drive(1'b1, frm[j], j == 0, j == flen - 1);
    end
  endtask

  // send, check vector and pulse after eof, then check the pulse ends
  task automatic frame_check(string req, string s, int gap_pct);
    logic [NP-1:0] e;
    load(s);
    e = ref_scan();
    send_frame(gap_pct);
    chk({req, " end"}, {hit, match}, {|e, e});
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    chk({req, " R7 pulse ends"}, {hit, match}, {1'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish, got timeout expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; valid = 1'b0; data = '0; sof = 1'b0; eof = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {hit, match}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {hit, match}, '0);

    // R2: offset 0, bit sets the cycle after the completing byte
    drive(1'b1, "a", 1'b1, 1'b0);
    drive(1'b1, "b", 1'b0, 1'b0);
    chk("R2 before completion", {1'b0, match}, '0);
    drive(1'b1, "b", 1'b0, 1'b0);
    chk("R2 offset0 timing", {1'b0, match}, {1'b0, 3'b001});
    drive(1'b1, "c", 1'b0, 1'b0);
    drive(1'b1, "c", 1'b0, 1'b1);
    chk("R4 sticky to eof", {hit, match}, {1'b1, 3'b001});
    repeat (3) drive(1'b0, "x", 1'b0, 1'b0);
    chk("R4 sticky over idle", {hit, match}, {1'b0, 3'b001});

    // R5: standalone start mark clears, then a clean frame
    drive(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R5 sof clears", {hit, match}, '0);
    frame_check("R2 last byte", "ccdcb", 0);
    frame_check("R3 repeat prefix", "aabbb", 0);
    frame_check("R3 overlap", "ababab", 0);
    frame_check("R8 no match", "cccccc", 0);
    frame_check("R2 all three", "abababbdcb", 0);

    // R5: string split across two frames
    frame_check("R5 frame A", "ccab", 0);
    frame_check("R5 split not seen", "bcc", 0);
    frame_check("R5 sof byte starts match", "dcbxx", 0);

    // R6: gap bytes carry data that must be ignored
    drive(1'b1, "a", 1'b1, 1'b0);
    drive(1'b1, "b", 1'b0, 1'b0);
    drive(1'b0, "d", 1'b0, 1'b0);
    drive(1'b0, "c", 1'b0, 1'b0);
    drive(1'b1, "b", 1'b0, 1'b0);
    chk("R6 gap keeps abb", {1'b0, match}, {1'b0, 3'b001});
    drive(1'b1, "d", 1'b0, 1'b0);
    drive(1'b0, "c", 1'b0, 1'b0);
    drive(1'b0, "b", 1'b0, 1'b0);
    drive(1'b1, "x", 1'b0, 1'b1);
    chk("R6 gap bytes ignored", {hit, match}, {1'b1, 3'b001});
    drive(1'b0, 8'h00, 1'b0, 1'b0);

    // R8: random frames over a small alphabet, with gaps
    for (int f = 0; f < 80; f++) begin
      logic [NP-1:0] e;
      flen = $urandom_range(1, 40);
      for (int j = 0; j < flen; j++)
        frm[j] = ($urandom_range(9) == 0) ? 8'($urandom) : 8'("a" + $urandom_range(3));
      e = ref_scan();
      send_frame(20);
      chk("R8 random frame", {hit, match}, {|e, e});
      drive(1'b0, 8'h00, 1'b0, 1'b0);
      chk("R7 random pulse ends", {hit, match}, {1'b0, e});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule